// File: doc/BRIEF.md
# Settable BCD Time-of-Day Clock

This block keeps a 24-hour time of day as six BCD digits, ordered hour tens, hour units, minute tens, minute units, second tens and second units. A prescaler counts system clock cycles and produces a one-cycle seconds pulse once per `DIV_COUNT` cycles. The default of 12,000,000 suits a 12 MHz clock. Each seconds pulse advances the running time by one second. The digits roll over in clock radix, and the hours run from 00 to 23.

Beside the running time sits an edit buffer, which four single-cycle key pulses control. The keys arrive already debounced.
- The select key moves a cursor over the six digit positions.
- The up and down keys change the digit under the cursor. Each digit has its own limit, and the hour-units limit follows the hour-tens value, so the buffer can never hold an illegal time.
- The load key copies the whole buffer into the running clock and restarts the prescaler.

A one-cycle top-of-hour pulse marks every change of the running time into minutes and seconds 00:00.

Top module: `tod_clock`

## Requirements
- R1: After reset the running time is 00:00:00 and `top_of_hour` is low. The edit buffer holds 13:59:50 and the cursor is at position 0.
- R2: The running time advances by exactly one second on the clock edge that ends every `DIV_COUNT`-th cycle counted from reset or from the last load. Between those edges the running time does not change.
- R3: Digits roll over in clock radix. Second units and minute units wrap 9 to 0, second tens and minute tens wrap 5 to 0, and 23:59:59 is followed by 00:00:00.
- R4: Each `key_sel` pulse advances the cursor by one through positions 0 to 5, wrapping from 5 to 0. Position 0 is hour tens, 1 hour units, 2 minute tens, 3 minute units, 4 second tens and 5 second units. A key pulse in the same cycle as `key_sel` acts on the old position.
- R5: A `key_up` pulse increments the digit under the cursor and wraps it to 0 after its limit. The limits are 2 for hour tens, 5 for both tens digits of minutes and seconds, and 9 for minute units and second units. For hour units the limit is 3 when hour tens is 2, and 9 otherwise.
- R6: A `key_dn` pulse decrements the digit under the cursor and wraps it from 0 to that digit's limit. When `key_up` and `key_dn` pulse together, only the increment happens.
- R7: When a change to hour tens leaves it at 2 while hour units is above 3, hour units becomes 3 in the same step.
- R8: On the edge where `key_load` is high, the running time takes the edit-buffer value held before that edge and the prescaler restarts from zero. This holds even if a seconds pulse falls on the same edge, and an edit in the same cycle does not reach the running time.
- R9: `top_of_hour` is high for exactly one cycle, the cycle after the running time changes into minutes and seconds 00:00 from any other value. The change can come from a tick or from a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_sel | input | 1 | Cursor advance pulse |
| key_up | input | 1 | Increment pulse for the digit under the cursor |
| key_dn | input | 1 | Decrement pulse for the digit under the cursor |
| key_load | input | 1 | Copy the edit buffer into the running clock |
| hour_tens | output | 4 | Running hour tens digit (BCD) |
| hour_units | output | 4 | Running hour units digit (BCD) |
| min_tens | output | 4 | Running minute tens digit (BCD) |
| min_units | output | 4 | Running minute units digit (BCD) |
| sec_tens | output | 4 | Running second tens digit (BCD) |
| sec_units | output | 4 | Running second units digit (BCD) |
| top_of_hour | output | 1 | One-cycle pulse on entry into mm:ss = 00:00 |

## Verification
A load and a seconds pulse can fall on the same clock edge. Under a short prescaler, the bench provokes this by raising `key_load` for exactly the cycle in which the counter sits at its last count. The check passes only if the buffer value appears unadvanced and the next second arrives a full period later. In the same way, an increment issued in the load cycle must stay out of the running time. It must reach the running time only on a later load.

// File: rtl/tod_pkg.sv
package tod_pkg;

   localparam int DIGIT_W    = 4;
   localparam int NUM_DIGITS = 6;
   localparam int CUR_W      = $clog2(NUM_DIGITS);

   // digit positions, in cursor order
   localparam int IDX_HT = 0;
   localparam int IDX_HU = 1;
   localparam int IDX_MT = 2;
   localparam int IDX_MU = 3;
   localparam int IDX_ST = 4;
   localparam int IDX_SU = 5;

   typedef logic [DIGIT_W-1:0] bcd_t;
   typedef bcd_t [NUM_DIGITS-1:0] tod_t;

   // 13:59:50, element 0 is hour tens
   localparam tod_t EDIT_INIT = {4'd0, 4'd5, 4'd9, 4'd5, 4'd3, 4'd1};

   function automatic bcd_t digit_limit(input logic [CUR_W-1:0] idx, input bcd_t ht);
      case (idx)
         CUR_W'(IDX_HT): return 4'd2;
         CUR_W'(IDX_HU): return (ht == 4'd2) ? 4'd3 : 4'd9;
         CUR_W'(IDX_MT),
         CUR_W'(IDX_ST): return 4'd5;
         default:        return 4'd9;
      endcase
   endfunction

   function automatic logic mmss_zero(input tod_t t);
      return (t[IDX_MT] == 4'd0) && (t[IDX_MU] == 4'd0) &&
             (t[IDX_ST] == 4'd0) && (t[IDX_SU] == 4'd0);
   endfunction

   function automatic tod_t tod_increment(input tod_t t_in);
      tod_t t;
      t = t_in;
      if (t[IDX_SU] != 4'd9) t[IDX_SU] = t[IDX_SU] + 4'd1;
      else begin
         t[IDX_SU] = 4'd0;
         if (t[IDX_ST] != 4'd5) t[IDX_ST] = t[IDX_ST] + 4'd1;
         else begin
            t[IDX_ST] = 4'd0;
            if (t[IDX_MU] != 4'd9) t[IDX_MU] = t[IDX_MU] + 4'd1;
            else begin
               t[IDX_MU] = 4'd0;
               if (t[IDX_MT] != 4'd5) t[IDX_MT] = t[IDX_MT] + 4'd1;
               else begin
                  t[IDX_MT] = 4'd0;
                  if (t[IDX_HT] == 4'd2 && t[IDX_HU] == 4'd3) begin
                     t[IDX_HT] = 4'd0;
                     t[IDX_HU] = 4'd0;
                  end else if (t[IDX_HU] == 4'd9) begin
                     t[IDX_HU] = 4'd0;
                     t[IDX_HT] = t[IDX_HT] + 4'd1;
                  end else begin
                     t[IDX_HU] = t[IDX_HU] + 4'd1;
                  end
               end
            end
         end
      end
      return t;
   endfunction

endpackage

// File: rtl/tod_tick_gen.sv
module tod_tick_gen #(
   parameter int DIV_COUNT = 12_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   localparam int CNT_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;

   generate
      if (DIV_COUNT == 1) begin : g_every_cycle
         assign tick = 1'b1;
      end else begin : g_counter
         logic [CNT_W-1:0] cnt_q;

         assign tick = (cnt_q == CNT_W'(DIV_COUNT - 1));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                cnt_q <= '0;
            else if (restart || tick)  cnt_q <= '0;
            else                       cnt_q <= cnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/tod_editor.sv
module tod_editor
   import tod_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic key_sel,
   input  logic key_up,
   input  logic key_dn,
   output tod_t edit_q
);

   logic [CUR_W-1:0] cursor_q;
   tod_t             edit_nxt;
   bcd_t             lim;

   always_comb begin
      edit_nxt = edit_q;
      lim      = '0;
      for (int i = 0; i < NUM_DIGITS; i++) begin
         if (cursor_q == CUR_W'(i)) begin
            lim = digit_limit(CUR_W'(i), edit_q[IDX_HT]);
            if (key_up)
               edit_nxt[i] = (edit_q[i] >= lim) ? '0 : edit_q[i] + 1'b1;
            else if (key_dn)
               edit_nxt[i] = (edit_q[i] == '0) ? lim : edit_q[i] - 1'b1;
         end
      end
      // keep hour units legal when hour tens lands on 2
      if ((key_up || key_dn) && (cursor_q == CUR_W'(IDX_HT)) &&
          (edit_nxt[IDX_HT] == 4'd2) && (edit_nxt[IDX_HU] > 4'd3))
         edit_nxt[IDX_HU] = 4'd3;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cursor_q <= '0;
         edit_q   <= EDIT_INIT;
      end else begin
         edit_q <= edit_nxt;
         if (key_sel)
            cursor_q <= (cursor_q == CUR_W'(NUM_DIGITS - 1)) ? '0 : cursor_q + 1'b1;
      end
   end

endmodule

// File: rtl/tod_counter.sv
module tod_counter
   import tod_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load,
   input  tod_t edit_time,
   output tod_t run_q,
   output logic top_q
);

   tod_t run_nxt;

   always_comb begin
      if (load)      run_nxt = edit_time;
      else if (tick) run_nxt = tod_increment(run_q);
      else           run_nxt = run_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= '0;
         top_q <= 1'b0;
      end else begin
         run_q <= run_nxt;
         top_q <= mmss_zero(run_nxt) && !mmss_zero(run_q);
      end
   end

endmodule

// File: rtl/tod_clock.sv
module tod_clock
   import tod_pkg::*;
#(
   parameter int DIV_COUNT = 12_000_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_sel,
   input  logic       key_up,
   input  logic       key_dn,
   input  logic       key_load,
   output logic [3:0] hour_tens,
   output logic [3:0] hour_units,
   output logic [3:0] min_tens,
   output logic [3:0] min_units,
   output logic [3:0] sec_tens,
   output logic [3:0] sec_units,
   output logic       top_of_hour
);

   generate
      if (DIV_COUNT < 1) begin : g_bad_div
         $error("tod_clock: DIV_COUNT must be at least 1");
      end
      if (DIGIT_W != 4) begin : g_bad_digit
         $error("tod_clock: digits must be 4-bit BCD");
      end
   endgenerate

   logic tick_w;
   tod_t edit_w;
   tod_t run_w;

   tod_tick_gen #(.DIV_COUNT(DIV_COUNT)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (key_load),
      .tick    (tick_w)
   );

   tod_editor u_edit (
      .clk     (clk),
      .rst_n   (rst_n),
      .key_sel (key_sel),
      .key_up  (key_up),
      .key_dn  (key_dn),
      .edit_q  (edit_w)
   );

   tod_counter u_run (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick_w),
      .load      (key_load),
      .edit_time (edit_w),
      .run_q     (run_w),
      .top_q     (top_of_hour)
   );

   assign hour_tens  = run_w[IDX_HT];
   assign hour_units = run_w[IDX_HU];
   assign min_tens   = run_w[IDX_MT];
   assign min_units  = run_w[IDX_MU];
   assign sec_tens   = run_w[IDX_ST];
   assign sec_units  = run_w[IDX_SU];

endmodule

// File: rtl/tod_clock_chk.sv
module tod_clock_chk
   import tod_pkg::*;
(
   input logic       clk,
   input logic       rst_n,
   input logic       key_load,
   input logic       tick,
   input tod_t       edit_time,
   input logic [3:0] hour_tens,
   input logic [3:0] hour_units,
   input logic [3:0] min_tens,
   input logic [3:0] min_units,
   input logic [3:0] sec_tens,
   input logic [3:0] sec_units,
   input logic       top_of_hour
);

   logic [23:0] shown;
   assign shown = {sec_units, sec_tens, min_units, min_tens, hour_units, hour_tens};

   assert_digit_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sec_units <= 4'd9) && (sec_tens <= 4'd5) && (min_units <= 4'd9) && (min_tens <= 4'd5) &&
      (((hour_tens < 4'd2) && (hour_units <= 4'd9)) || ((hour_tens == 4'd2) && (hour_units <= 4'd3))));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick && !key_load) |=> $stable(shown));

   assert_load_copy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      key_load |=> (shown == $past(edit_time)));

   assert_edit_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (edit_time[IDX_HT] == 4'd2) |-> (edit_time[IDX_HU] <= 4'd3));

   assert_pulse_at_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      top_of_hour |-> ((min_tens == 4'd0) && (min_units == 4'd0) &&
                       (sec_tens == 4'd0) && (sec_units == 4'd0)));

   assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      top_of_hour |=> !top_of_hour);

endmodule

bind tod_clock tod_clock_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .key_load    (key_load),
   .tick        (tick_w),
   .edit_time   (edit_w),
   .hour_tens   (hour_tens),
   .hour_units  (hour_units),
   .min_tens    (min_tens),
   .min_units   (min_units),
   .sec_tens    (sec_tens),
   .sec_units   (sec_units),
   .top_of_hour (top_of_hour)
);

// File: tb/sim_tod_clock.sv
module sim_tod_clock;

   localparam int DIV = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic key_sel = 1'b0, key_up = 1'b0, key_dn = 1'b0, key_load = 1'b0;
   logic [3:0] hour_tens, hour_units, min_tens, min_units, sec_tens, sec_units;
   logic top_of_hour;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tod_clock #(.DIV_COUNT(DIV)) u0 (
      .clk(clk), .rst_n(rst_n),
      .key_sel(key_sel), .key_up(key_up), .key_dn(key_dn), .key_load(key_load),
      .hour_tens(hour_tens), .hour_units(hour_units),
      .min_tens(min_tens), .min_units(min_units),
      .sec_tens(sec_tens), .sec_units(sec_units),
      .top_of_hour(top_of_hour)
   );

   wire [23:0] shown = {hour_tens, hour_units, min_tens, min_units, sec_tens, sec_units};

   task automatic check_time(input string tag, input logic [23:0] exp);
      checks++;
      if (shown !== exp) begin
         failures++;
         $display("FAIL %s time=%h expected=%h", tag, shown, exp);
      end
   endtask

   task automatic check_pulse(input string tag, input logic exp);
      checks++;
      if (top_of_hour !== exp) begin
         failures++;
         $display("FAIL %s top_of_hour=%b expected=%b", tag, top_of_hour, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      {key_sel, key_up, key_dn, key_load} = 4'b0000;
      wait_cyc(3);
      rst_n = 1'b1;
   endtask

   task automatic press(input logic s, input logic u, input logic d, input logic l);
      @(negedge clk);
      {key_sel, key_up, key_dn, key_load} = {s, u, d, l};
      @(negedge clk);
      {key_sel, key_up, key_dn, key_load} = 4'b0000;
   endtask

   task automatic sel_n(input int n);
      for (int i = 0; i < n; i++) press(1'b1, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_reset_and_tick();
      do_reset();
      check_time("R1 reset time", 24'h000000);
      check_pulse("R1 reset pulse", 1'b0);
      wait_cyc(DIV - 1);
      check_time("R2 before first tick", 24'h000000);
      wait_cyc(1);
      check_time("R2 first tick", 24'h000001);
      wait_cyc(DIV);
      check_time("R2 second tick", 24'h000002);
   endtask

   task automatic t_top_of_hour();
      do_reset();
      press(1'b0, 1'b0, 1'b0, 1'b1);
      check_time("R1 edit buffer reset value", 24'h135950);
      wait_cyc(DIV * 10 - 1);
      check_time("R3 last second of hour", 24'h135959);
      check_pulse("R9 no pulse before rollover", 1'b0);
      wait_cyc(1);
      check_time("R3 minute and hour carry", 24'h140000);
      check_pulse("R9 pulse on rollover", 1'b1);
      wait_cyc(1);
      check_pulse("R9 pulse lasts one cycle", 1'b0);
   endtask

   task automatic t_increment();
      do_reset();
      press(1'b0, 1'b1, 1'b0, 1'b0);              // ht 1->2
      press(1'b0, 1'b1, 1'b0, 1'b0);              // ht 2->0
      press(1'b0, 1'b0, 1'b0, 1'b1);
      check_time("R5 hour tens wraps 2 to 0", 24'h035950);
      press(1'b0, 1'b1, 1'b0, 1'b0);
      press(1'b0, 1'b1, 1'b0, 1'b0);              // ht 0->2
      sel_n(1);
      press(1'b0, 1'b1, 1'b0, 1'b0);              // hu 3->0 with ht=2
      press(1'b0, 1'b0, 1'b0, 1'b1);
      check_time("R5 hour units limit 3 under 2x", 24'h205950);
      sel_n(1);
      press(1'b0, 1'b1, 1'b0, 1'b0);              // mt 5->0
      sel_n(1);
      press(1'b0, 1'b1, 1'b0, 1'b0);              // mu 9->0
      sel_n(1);
      press(1'b0, 1'b1, 1'b0, 1'b0);              // st 5->0
      press(1'b0, 1'b0, 1'b0, 1'b1);
      check_time("R4 R5 tens and units limits", 24'h200000);
      check_pulse("R9 pulse after load into 00:00", 1'b1);
      sel_n(1);
      press(1'b0, 1'b1, 1'b0, 1'b0);              // su 0->1
      sel_n(1);                                   // cursor 5->0
      press(1'b0, 1'b1, 1'b0, 1'b0);              // ht 2->0
      press(1'b0, 1'b0, 1'b0, 1'b1);
      check_time("R4 cursor wraps to hour tens", 24'h000001);
   endtask

   task automatic t_decrement();
      do_reset();
      press(1'b0, 1'b0, 1'b1, 1'b0);              // ht 1->0
      press(1'b0, 1'b0, 1'b0, 1'b1);
      check_time("R6 decrement hour tens", 24'h035950);
      press(1'b0, 1'b0, 1'b1, 1'b0);              // ht 0->2
      sel_n(5);
      press(1'b0, 1'b0, 1'b1, 1'b0);              // su 0->9
      press(1'b0, 1'b0, 1'b0, 1'b1);
      check_time("R6 decrement wraps to limit", 24'h235959);
      wait_cyc(DIV);
      check_time("R3 day wrap", 24'h000000);
      check_pulse("R9 pulse on day wrap", 1'b1);
      press(1'b0, 1'b1, 1'b1, 1'b0);              // up wins: su 9->0
      press(1'b0, 1'b0, 1'b0, 1'b1);
      check_time("R6 up has priority over down", 24'h235950);
   endtask

   task automatic t_clamp();
      do_reset();
      sel_n(1);
      press(1'b0, 1'b1, 1'b0, 1'b0);              // hu 3->4
      sel_n(5);
      press(1'b0, 1'b1, 1'b0, 1'b0);              // ht 1->2, hu clamped
      press(1'b0, 1'b0, 1'b0, 1'b1);
      check_time("R7 clamp on increment", 24'h235950);
      press(1'b0, 1'b0, 1'b1, 1'b0);              // ht 2->1
      press(1'b0, 1'b0, 1'b1, 1'b0);              // ht 1->0
      sel_n(1);
      press(1'b0, 1'b1, 1'b0, 1'b0);              // hu 3->4
      sel_n(5);
      press(1'b0, 1'b0, 1'b1, 1'b0);              // ht 0->2, hu clamped
      press(1'b0, 1'b0, 1'b0, 1'b1);
      check_time("R7 clamp on decrement", 24'h235950);
   endtask

   task automatic t_load_vs_tick();
      do_reset();
      wait_cyc(DIV - 1);
      key_load = 1'b1;                            // high on the tick edge
      @(negedge clk);
      key_load = 1'b0;
      check_time("R8 load wins over tick", 24'h135950);
      wait_cyc(DIV - 1);
      check_time("R8 prescaler restarted", 24'h135950);
      wait_cyc(1);
      check_time("R8 first second after load", 24'h135951);
      press(1'b0, 1'b1, 1'b0, 1'b1);              // edit and load together
      check_time("R8 same-cycle edit not loaded", 24'h135950);
      press(1'b0, 1'b0, 1'b0, 1'b1);
      check_time("R8 edit visible on next load", 24'h235950);
   endtask

   initial begin
      t_reset_and_tick();
      t_top_of_hour();
      t_increment();
      t_decrement();
      t_clamp();
      t_load_vs_tick();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired, done=%b expected=1", done);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule